// File: doc/BRIEF.md
# Single-Bit Instruction Execution Unit

This unit carries out the single-bit instructions of a 32-bit processor that keeps a one-bit condition flag, called T here. An instruction arrives as one or two halfwords together with a valid strobe. The unit takes it only while it is idle. It decodes the instruction and then changes one bit of a general register, or one bit of a byte in memory. Some variants instead fold the selected bit into T.

Register variants act on bits 0 to 7 of the named register and take one execution cycle. Memory variants address the byte at Rn plus a zero-extended 12-bit offset. They take three execution cycles: the address is formed, the byte is fetched, and the last cycle either writes back the changed byte or updates T. A low memory ready stalls the sequence. The register file is read combinationally and written through its own port. T is read from `t_in` and is replaced only when `t_we` is high.

Top module: `bitop_exec_unit`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, illegal, rf_we, mem_re, mem_we and t_we are low until an instruction is accepted.
- R2: Register clear and set, halfword {1000011, 0, nnnn, k, iii}: k=0 clears and k=1 sets bit iii of Rn. All other bits are kept, and T and memory are not written.
- R3: Register store and load, halfword {1000011, 1, nnnn, k, iii}: k=0 copies T into bit iii of Rn and leaves T alone. k=1 copies bit iii of Rn into T and leaves Rn unwritten.
- R4: Memory form, first halfword {0011, nnnn, 0, iii, 1001}, second halfword {op[3:0], disp[11:0]}. The byte is read at Rn + zero-extended disp, modulo 2^32.
- R5: Memory ops 0, 1 and 2 clear bit iii, set bit iii, or copy T into bit iii. They write the byte back once at the same address, keep the other seven bits, and leave T unwritten.
- R6: Memory ops that only update T: 3 loads bit iii, 4 ANDs it with T and 5 ORs it with T. Ops B, C and D do the same with the inverted bit. None of them writes memory.
- R7: When memory ready is high, done comes in the first cycle after acceptance for a register form and in the third cycle for a memory form. done is a one-cycle pulse and is only high while busy is high.
- R8: Each cycle that the read sees ready low adds one cycle. The address and the read request are held until ready is high.
- R9: A memory op nibble of 6, 7, 8, 9, A, E or F, or a first halfword that matches neither form, gives a single cycle with illegal and done high. It writes no register, memory byte or T.
- R10: busy is high from the cycle after acceptance up to and including the done cycle. A valid instruction offered while busy is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction offered; taken when the unit is idle |
| insn_hi | input | 16 | First instruction halfword |
| insn_lo | input | 16 | Second halfword (memory form only) |
| rf_raddr | output | 4 | Register read index |
| rf_rdata | input | 32 | Register read data, combinational |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 4 | Register write index |
| rf_wdata | output | 32 | Register write data |
| mem_addr | output | 32 | Byte address |
| mem_re | output | 1 | Byte read request |
| mem_we | output | 1 | Byte write request |
| mem_wdata | output | 8 | Byte write data |
| mem_rdata | input | 8 | Byte read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the current request |
| t_in | input | 1 | Current T flag |
| t_we | output | 1 | T update enable |
| t_out | output | 1 | New T value |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of an instruction |
| illegal | output | 1 | Instruction not recognised |

## Verification
The stall and single-commit properties assume two things of the environment. It looks at mem_ready only while a request is raised, and it commits a write only in the cycle where the enable and ready are both high. The bench lowers ready only during the read and applies every commit in the done cycle. The properties also assume that insn_hi and insn_lo matter only in the cycle of acceptance. The bench changes every input at the falling edge and drops valid as soon as the instruction is taken, except in the test that deliberately offers one while busy.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  localparam int REG_IDX_W = 4;
  localparam int BIT_IDX_W = 3;
  localparam int DISP_W    = 12;
  localparam int BYTE_W    = 1 << BIT_IDX_W;

  typedef enum logic [3:0] {
    OP_CLR, OP_SET, OP_STT, OP_LDT, OP_LDN,
    OP_AND, OP_ANDN, OP_OR, OP_ORN, OP_BAD
  } bitop_e;

  typedef struct packed {
    logic                 legal;
    logic                 is_mem;
    bitop_e               op;
    logic [REG_IDX_W-1:0] rn;
    logic [BIT_IDX_W-1:0] bidx;
    logic [DISP_W-1:0]    disp;
  } bitop_dec_t;

  function automatic logic op_writes(bitop_e op);
    return (op == OP_CLR) || (op == OP_SET) || (op == OP_STT);
  endfunction

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic [15:0] hi,
  input  logic [15:0] lo,
  output bitop_dec_t  dec
);

  always_comb begin
    dec    = '0;
    dec.op = OP_BAD;
    if (hi[15:9] == 7'b1000011) begin
      dec.legal = 1'b1;
      dec.rn    = hi[7:4];
      dec.bidx  = hi[2:0];
      unique case ({hi[8], hi[3]})
        2'b00:   dec.op = OP_CLR;
        2'b01:   dec.op = OP_SET;
        2'b10:   dec.op = OP_STT;
        default: dec.op = OP_LDT;
      endcase
    end else if (hi[15:12] == 4'b0011 && !hi[7] && hi[3:0] == 4'b1001) begin
      dec.is_mem = 1'b1;
      dec.rn     = hi[11:8];
      dec.bidx   = hi[6:4];
      dec.disp   = lo[11:0];
      unique case (lo[15:12])
        4'h0:    dec.op = OP_CLR;
        4'h1:    dec.op = OP_SET;
        4'h2:    dec.op = OP_STT;
        4'h3:    dec.op = OP_LDT;
        4'hB:    dec.op = OP_LDN;
        4'h4:    dec.op = OP_AND;
        4'hC:    dec.op = OP_ANDN;
        4'h5:    dec.op = OP_OR;
        4'hD:    dec.op = OP_ORN;
        default: dec.op = OP_BAD;
      endcase
      dec.legal = (dec.op != OP_BAD);
    end
  end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DW = 8
) (
  input  bitop_e               op,
  input  logic [BIT_IDX_W-1:0] bidx,
  input  logic [DW-1:0]        din,
  input  logic                 t_in,
  output logic [DW-1:0]        dout,
  output logic                 t_res
);

  logic [DW-1:0] mask;
  logic          sel;

  assign mask = DW'(1) << bidx;
  assign sel  = |(din & mask);

  always_comb begin
    dout  = din;
    t_res = t_in;
    unique case (op)
      OP_CLR:  dout  = din & ~mask;
      OP_SET:  dout  = din | mask;
      OP_STT:  dout  = t_in ? (din | mask) : (din & ~mask);
      OP_LDT:  t_res = sel;
      OP_LDN:  t_res = ~sel;
      OP_AND:  t_res = sel & t_in;
      OP_ANDN: t_res = ~sel & t_in;
      OP_OR:   t_res = sel | t_in;
      OP_ORN:  t_res = ~sel | t_in;
      default: begin
        dout  = din;
        t_res = t_in;
      end
    endcase
  end

endmodule

// File: rtl/bitop_exec_unit.sv
module bitop_exec_unit
  import bitop_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 insn_valid,
  input  logic [15:0]          insn_hi,
  input  logic [15:0]          insn_lo,
  output logic [REG_IDX_W-1:0] rf_raddr,
  input  logic [XLEN-1:0]      rf_rdata,
  output logic                 rf_we,
  output logic [REG_IDX_W-1:0] rf_waddr,
  output logic [XLEN-1:0]      rf_wdata,
  output logic [XLEN-1:0]      mem_addr,
  output logic                 mem_re,
  output logic                 mem_we,
  output logic [BYTE_W-1:0]    mem_wdata,
  input  logic [BYTE_W-1:0]    mem_rdata,
  input  logic                 mem_ready,
  input  logic                 t_in,
  output logic                 t_we,
  output logic                 t_out,
  output logic                 busy,
  output logic                 done,
  output logic                 illegal
);

  typedef enum logic [2:0] {S_IDLE, S_REG, S_ADDR, S_READ, S_WB, S_ILL} st_e;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  bitop_dec_t dec_w;
  bitop_decode u_dec (.hi(insn_hi), .lo(insn_lo), .dec(dec_w));

  st_e                  state_q, state_d;
  bitop_e               op_q;
  logic [REG_IDX_W-1:0] rn_q;
  logic [BIT_IDX_W-1:0] bidx_q;
  logic [DISP_W-1:0]    disp_q;
  logic [XLEN-1:0]      addr_q, addr_d;
  logic [BYTE_W-1:0]    byte_q;
  logic                 accept, addr_en, byte_en, wr_op;

  assign wr_op   = op_writes(op_q);
  assign addr_d  = rf_rdata + XLEN'(disp_q);
  assign addr_en = (state_q == S_ADDR);
  assign byte_en = (state_q == S_READ) && mem_ready;

  // next state
  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    unique case (state_q)
      S_IDLE: if (insn_valid) begin
        accept = 1'b1;
        if (!dec_w.legal)     state_d = S_ILL;
        else if (dec_w.is_mem) state_d = S_ADDR;
        else                   state_d = S_REG;
      end
      S_REG:  state_d = S_IDLE;
      S_ILL:  state_d = S_IDLE;
      S_ADDR: state_d = S_READ;
      S_READ: if (mem_ready) state_d = S_WB;
      S_WB:   if (!wr_op || mem_ready) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      state_q <= S_IDLE;
      op_q    <= OP_BAD;
      rn_q    <= '0;
      bidx_q  <= '0;
      disp_q  <= '0;
      addr_q  <= '0;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q   <= dec_w.op;
        rn_q   <= dec_w.rn;
        bidx_q <= dec_w.bidx;
        disp_q <= dec_w.disp;
      end
      if (addr_en) addr_q <= addr_d;
      if (byte_en) byte_q <= mem_rdata;
    end
  end

  logic [XLEN-1:0]   reg_new;
  logic              reg_t;
  logic [BYTE_W-1:0] byte_new;
  logic              byte_t;

  bitop_alu #(.DW(XLEN)) u_reg_alu (
    .op(op_q), .bidx(bidx_q), .din(rf_rdata), .t_in(t_in),
    .dout(reg_new), .t_res(reg_t)
  );

  bitop_alu #(.DW(BYTE_W)) u_byte_alu (
    .op(op_q), .bidx(bidx_q), .din(byte_q), .t_in(t_in),
    .dout(byte_new), .t_res(byte_t)
  );

  assign rf_raddr  = rn_q;
  assign rf_waddr  = rn_q;
  assign rf_wdata  = reg_new;
  assign mem_addr  = addr_q;
  assign mem_wdata = byte_new;
  assign busy      = (state_q != S_IDLE);

  // outputs
  always_comb begin
    rf_we   = 1'b0;
    mem_re  = 1'b0;
    mem_we  = 1'b0;
    t_we    = 1'b0;
    t_out   = t_in;
    done    = 1'b0;
    illegal = 1'b0;
    unique case (state_q)
      S_REG: begin
        rf_we = wr_op;
        t_we  = !wr_op;
        t_out = reg_t;
        done  = 1'b1;
      end
      S_READ: mem_re = 1'b1;
      S_WB: begin
        if (wr_op) begin
          mem_we = 1'b1;
          done   = mem_ready;
        end else begin
          t_we  = 1'b1;
          t_out = byte_t;
          done  = 1'b1;
        end
      end
      S_ILL: begin
        illegal = 1'b1;
        done    = 1'b1;
      end
      default: ;
    endcase
  end

  // R9: an unrecognised instruction commits nothing
  a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && !rf_we && !mem_we && !t_we));

  // R5, R6: at most one kind of commit per cycle
  a_r6_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, mem_we, t_we}));

  // R4: a read and a write are never requested together
  a_r4_no_re_we: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  // R8: a stalled read keeps its request and address
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && !mem_ready) |=> (mem_re && $stable(mem_addr)));

  // R7: done only while busy and never two cycles in a row
  a_r7_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: busy holds until the instruction completes
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R5: a write-back only follows a read of the same address
  a_r5_wb_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> ($past(mem_re) && $stable(mem_addr)));

endmodule

// File: tb/tb_bitop_exec_unit.sv
`timescale 1ns/1ps
module tb_bitop_exec_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_valid;
  logic [15:0] insn_hi, insn_lo;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata, mem_addr;
  logic        rf_we, mem_re, mem_we, mem_ready, t_we, t_out, busy, done, illegal;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        tflag;

  logic [31:0] regs [16];
  logic [7:0]  mem  [256];

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  assign rf_rdata  = regs[rf_raddr];
  assign mem_rdata = mem[mem_addr[7:0]];

  bitop_exec_unit dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_hi(insn_hi), .insn_lo(insn_lo),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .t_in(tflag), .t_we(t_we), .t_out(t_out),
    .busy(busy), .done(done), .illegal(illegal)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // offer one instruction, emulate memory and register file, commit in the done cycle
  task automatic run(input logic [15:0] hi, input logic [15:0] lo, input int stall,
                     output int cyc, output logic ill, output logic [31:0] raddr,
                     output int nwr, output int nrf, output int nt);
    int waited;
    waited = 0; ill = 1'b0; raddr = '0; nwr = 0; nrf = 0; nt = 0;
    @(negedge clk);
    insn_hi = hi; insn_lo = lo; insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
    cyc = 1;
    forever begin
      if (mem_re && waited < stall) begin
        mem_ready = 1'b0;
        waited++;
      end else begin
        mem_ready = 1'b1;
      end
      #1;
      if (mem_re && mem_ready) raddr = mem_addr;
      if (done) begin
        ill = illegal;
        if (rf_we) begin regs[rf_waddr] = rf_wdata; nrf++; end
        if (mem_we && mem_ready) begin mem[mem_addr[7:0]] = mem_wdata; nwr++; end
        if (t_we) begin tflag = t_out; nt++; end
        break;
      end
      if (cyc >= 64) begin
        check("R7 instruction never completed", 32'(cyc), 32'd0);
        break;
      end
      @(negedge clk);
      cyc++;
    end
    mem_ready = 1'b1;
  endtask

  initial begin
    #(5.0 * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int cyc, nwr, nrf, nt;
    logic ill, texp, bv, c;
    logic [31:0] raddr, v, vexp, base, addr;
    logic [7:0] m, mexp;
    logic [3:0] n, rn;
    logic [11:0] disp;
    logic [3:0] nibs [9];
    logic [3:0] bad [7];
    logic seen_rf;
    nibs = '{4'h0, 4'h1, 4'h2, 4'h3, 4'hB, 4'h4, 4'hC, 4'h5, 4'hD};
    bad  = '{4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hE, 4'hF};

    for (int i = 0; i < 16; i++) regs[i] = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rst_n = 1'b0; insn_valid = 1'b0; insn_hi = '0; insn_lo = '0; mem_ready = 1'b1; tflag = 1'b0;

    // R1: quiet during and after reset
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {26'd0, busy, done, illegal, rf_we, mem_re, mem_we | t_we}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 outputs after release", {26'd0, busy, done, illegal, rf_we, mem_re, mem_we | t_we}, 32'd0);

    // R2, R3: register forms, k selects clear/set/store/load
    for (int k = 0; k < 4; k++)
      for (int b = 0; b < 8; b++)
        for (int t = 0; t < 2; t++)
          for (int p = 0; p < 2; p++) begin
            rn = 4'((k * 4 + b) % 16);
            v  = p ? 32'hA5A5_5A5A : 32'h5A5A_A5A5;
            regs[rn] = v; tflag = t[0];
            run({7'b1000011, k[1], rn, k[0], b[2:0]}, 16'h0000, 0, cyc, ill, raddr, nwr, nrf, nt);
            case (k)
              0: vexp = v & ~(32'd1 << b);
              1: vexp = v | (32'd1 << b);
              2: vexp = t[0] ? (v | (32'd1 << b)) : (v & ~(32'd1 << b));
              default: vexp = v;
            endcase
            texp = (k == 3) ? v[b] : t[0];
            check(k < 2 ? "R2 register result" : "R3 register result", regs[rn], vexp);
            check(k < 2 ? "R2 T unchanged" : "R3 T value", 32'(tflag), 32'(texp));
            check("R2 no memory write", 32'(nwr), 32'd0);
            check("R3 register writes", 32'(nrf), (k == 3) ? 32'd0 : 32'd1);
            check("R7 register form cycles", 32'(cyc), 32'd1);
          end

    // R4, R5, R6: memory forms over every legal op, bit, T and byte pattern
    for (int ni = 0; ni < 9; ni++)
      for (int b = 0; b < 8; b++)
        for (int t = 0; t < 2; t++)
          for (int p = 0; p < 2; p++) begin
            n    = nibs[ni];
            rn   = 4'((ni + b + p) % 16);
            base = (ni % 2 == 0) ? (32'h0000_1000 + 32'(ni * 16)) : (32'hFFFF_F800 + 32'(ni * 16));
            disp = 12'h800 | 12'(b * 64 + t * 8 + p * 4);
            addr = base + {20'd0, disp};
            m    = p ? 8'hA5 : 8'h5A;
            regs[rn] = base; mem[addr[7:0]] = m; tflag = t[0];
            run({4'b0011, rn, 1'b0, b[2:0], 4'b1001}, {n, disp}, 0, cyc, ill, raddr, nwr, nrf, nt);
            bv = m[b];
            c  = n[3] ? ~bv : bv;
            mexp = m; texp = t[0];
            case (n)
              4'h0: mexp = m & ~(8'd1 << b);
              4'h1: mexp = m | (8'd1 << b);
              4'h2: mexp = t[0] ? (m | (8'd1 << b)) : (m & ~(8'd1 << b));
              4'h3, 4'hB: texp = c;
              4'h4, 4'hC: texp = c & t[0];
              default: texp = c | t[0];
            endcase
            check("R4 read address", raddr, addr);
            check(n <= 4'h2 ? "R5 byte after write-back" : "R6 byte untouched", 32'(mem[addr[7:0]]), 32'(mexp));
            check(n <= 4'h2 ? "R5 T unchanged" : "R6 T result", 32'(tflag), 32'(texp));
            check(n <= 4'h2 ? "R5 one write-back" : "R6 no write-back", 32'(nwr), (n <= 4'h2) ? 32'd1 : 32'd0);
            check("R7 memory form cycles", 32'(cyc), 32'd3);
          end

    // R8: read stalls
    for (int s = 1; s < 4; s++)
      for (int w = 0; w < 2; w++) begin
        n = w ? 4'h1 : 4'h3;
        regs[3] = 32'h0000_2000; mem[8'h44] = 8'h10; tflag = 1'b0;
        run({4'b0011, 4'd3, 1'b0, 3'd4, 4'b1001}, {n, 12'h044}, s, cyc, ill, raddr, nwr, nrf, nt);
        check("R8 stalled cycles", 32'(cyc), 32'(3 + s));
        check("R8 stalled address", raddr, 32'h0000_2044);
        check("R8 stalled result", {23'd0, tflag, mem[8'h44]}, w ? {23'd0, 1'b0, 8'h10} : {23'd0, 1'b1, 8'h10});
      end

    // R9: unrecognised encodings
    for (int i = 0; i < 8; i++) begin
      regs[2] = 32'h0000_3000; mem[8'h10] = 8'h3C; tflag = i[0];
      if (i < 7)
        run({4'b0011, 4'd2, 1'b0, 3'd2, 4'b1001}, {bad[i], 12'h010}, 0, cyc, ill, raddr, nwr, nrf, nt);
      else
        run(16'hFFFF, 16'h0000, 0, cyc, ill, raddr, nwr, nrf, nt);
      check("R9 illegal flagged", 32'(ill), 32'd1);
      check("R9 illegal one cycle", 32'(cyc), 32'd1);
      check("R9 no commits", 32'(nwr + nrf + nt), 32'd0);
      check("R9 state preserved", {23'd0, tflag, mem[8'h10]}, {23'd0, i[0], 8'h3C});
    end

    // R10: a valid instruction offered while busy is not taken
    regs[5] = 32'h0; regs[1] = 32'h0000_4000; mem[8'h00] = 8'hFF; tflag = 1'b0;
    seen_rf = 1'b0;
    @(negedge clk);
    insn_hi = {4'b0011, 4'd1, 1'b0, 3'd0, 4'b1001}; insn_lo = {4'h3, 12'h000}; insn_valid = 1'b1;
    @(negedge clk);
    check("R10 busy after accept", 32'(busy), 32'd1);
    insn_hi = {7'b1000011, 1'b0, 4'd5, 1'b1, 3'd0}; insn_valid = 1'b1;
    @(negedge clk);
    check("R10 busy mid-sequence", 32'(busy), 32'd1);
    insn_valid = 1'b0;
    @(negedge clk);
    check("R10 done in third cycle", {30'd0, busy, done}, 32'd3);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      if (rf_we || busy) seen_rf = 1'b1;
    end
    check("R10 offered instruction dropped", 32'(seen_rf), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule